// File: doc/BRIEF.md
# Transmit Holding-Register Empty Interrupt Generator

This block derives the transmitter-empty status flag and the transmit interrupt request for a serial transmitter that sits behind a 16-entry transmit FIFO. It watches the FIFO occupancy, host writes to the holding register, host reads of the interrupt identification register, the serializer's last-stop-bit indication and the baud tick. From these it decides when the transmit side counts as empty. The FIFO storage, the serializer and arbitration against the other interrupt sources belong to neighbouring blocks.

When the FIFO drains, the flag normally rises on the next cycle. If the FIFO never held two or more bytes at once since the flag last rose, and the FIFO is enabled, the flag is held back. The hold lasts one character time minus the final stop bit, counted in baud ticks, or ends sooner when the serializer reports the last stop bit. A pending interrupt is raised on every rising edge of the flag. It is also raised when the FIFO-enable bit toggles while the transmitter is empty. It is dropped by a holding-register write or an identification read. The request leaves the block only while both the FIFO enable and the transmit interrupt enable are set.

The control is a three-state machine. `ST_EMPTY` is the reset state and the only state with the flag set. `ST_BUSY` means characters are queued. `ST_HOLD` is the delay window.

The transitions are:
- `ST_EMPTY`→`ST_BUSY` when the FIFO count becomes nonzero.
- `ST_BUSY`→`ST_EMPTY` when the count is zero and either the FIFO is disabled or two bytes were seen.
- `ST_BUSY`→`ST_HOLD` when the count is zero otherwise.
- `ST_HOLD`→`ST_BUSY` on a write or a nonzero count.
- `ST_HOLD`→`ST_EMPTY` when the hold counter expires or the last stop bit is reported.

Top module: `txe_irq_unit`

## Requirements
- R1: After reset `thre` is 1 and `tx_irq` is 0.
- R2: While `thre` is 1, a nonzero `fifo_level` clears `thre` on the next clock edge, and `thre` never falls unless the FIFO count was nonzero.
- R3: When `fifo_level` reaches 0 while the FIFO is disabled (`fifo_en`=0), or after the FIFO has held two or more bytes at once since `thre` last rose, `thre` rises on the next clock edge.
- R4: When `fifo_level` reaches 0 with the FIFO enabled and no two-byte occupancy seen, `thre` rises at the clock edge ending the L-th `baud_tick` after the hold begins. L is the data bit count plus one, and `char_sel` 0,1,2,3 selects 5,6,7,8 data bits (L = 6 to 9).
- R5: A `last_stop` pulse during the hold window ends it, and `thre` rises at that clock edge.
- R6: A holding-register write (`thr_wr`) during the hold window cancels it. `thre` stays 0, and a new full-length hold starts once the count is zero again.
- R7: A pending interrupt is set when `thre` rises. `tx_irq` is 1 only while the interrupt is pending and both `fifo_en` and `tx_ie` are 1.
- R8: `thr_wr` or `id_rd` clears the pending interrupt at the next clock edge, and a clear wins over a simultaneous set.
- R9: A change of `fifo_en` while the transmitter stays empty sets the pending interrupt at the next clock edge, with no delay. The enable tracker resets to 0.
- R10: The two-byte memory is cleared each time `thre` rises. A later single-byte burst is therefore delayed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_level | input | 5 | Characters currently in the transmit FIFO (0 to 16) |
| thr_wr | input | 1 | Host write strobe to the holding register |
| id_rd | input | 1 | Host read strobe of the interrupt identification register |
| last_stop | input | 1 | Serializer pulse: final stop bit of the current character has begun |
| baud_tick | input | 1 | One pulse per bit time |
| char_sel | input | 2 | Data bits per character: 0=5, 1=6, 2=7, 3=8 |
| fifo_en | input | 1 | FIFO enable control bit |
| tx_ie | input | 1 | Transmit interrupt enable |
| thre | output | 1 | Transmitter holding register empty flag |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
A stale two-byte memory shows at the ports in the cycle after the FIFO drains. `thre` then rises at once where a hold was due, or is held where it was not. A hold counter loaded or decremented wrongly moves the rising edge of `thre` by whole baud ticks, so exact tick counts at both ends of the character-length range expose it. A pending bit that fails to clear or set shows on `tx_irq` one cycle after the write, read, enable change or flag edge that should have moved it.

// File: rtl/txe_pkg.sv
package txe_pkg;
    localparam int CNT_W = 4;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_BUSY  = 2'd1,
        ST_HOLD  = 2'd2
    } txe_state_t;

    // start bit plus data bits: the character time short of its stop bit
    function automatic logic [CNT_W-1:0] hold_ticks(input logic [1:0] sel);
        return CNT_W'(sel) + CNT_W'(6);
    endfunction
endpackage

// File: rtl/txe_pair_tracker.sv
module txe_pair_tracker #(
    parameter int LEVEL_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LEVEL_W-1:0] level,
    input  logic               wipe,
    output logic               seen
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seen <= 1'b0;
        else if (wipe)
            seen <= 1'b0;
        else if (level >= LEVEL_W'(2))
            seen <= 1'b1;
    end
endmodule

// File: rtl/txe_hold_timer.sv
module txe_hold_timer
    import txe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       run,
    input  logic       tick,
    input  logic [1:0] sel,
    output logic       expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= hold_ticks(sel);
        else if (run && tick && cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign expire = run && tick && (cnt == CNT_W'(1));
endmodule

// File: rtl/txe_irq_unit.sv
module txe_irq_unit
    import txe_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int LEVEL_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LEVEL_W-1:0] fifo_level,
    input  logic               thr_wr,
    input  logic               id_rd,
    input  logic               last_stop,
    input  logic               baud_tick,
    input  logic [1:0]         char_sel,
    input  logic               fifo_en,
    input  logic               tx_ie,
    output logic               thre,
    output logic               tx_irq
);
    txe_state_t state, nxt;
    logic seen_two, hold_done, enter_hold, thre_set;
    logic fifo_en_q, pend;
    logic level_zero;

    assign level_zero = (fifo_level == '0);

    txe_pair_tracker #(.LEVEL_W(LEVEL_W)) u_pair (
        .clk   (clk),
        .rst_n (rst_n),
        .level (fifo_level),
        .wipe  (thre_set),
        .seen  (seen_two)
    );

    txe_hold_timer u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (enter_hold),
        .run    (state == ST_HOLD),
        .tick   (baud_tick),
        .sel    (char_sel),
        .expire (hold_done)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_EMPTY: if (!level_zero) nxt = ST_BUSY;
            ST_BUSY: begin
                if (level_zero)
                    nxt = (!fifo_en || seen_two) ? ST_EMPTY : ST_HOLD;
            end
            ST_HOLD: begin
                if (!level_zero || thr_wr)
                    nxt = ST_BUSY;
                else if (hold_done || last_stop)
                    nxt = ST_EMPTY;
            end
            default: nxt = ST_EMPTY;
        endcase
    end

    assign enter_hold = (state != ST_HOLD) && (nxt == ST_HOLD);
    assign thre_set   = (state != ST_EMPTY) && (nxt == ST_EMPTY);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_EMPTY;
        else
            state <= nxt;
    end

    // pending interrupt and enable tracker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            fifo_en_q <= 1'b0;
        end else begin
            fifo_en_q <= fifo_en;
            if (thr_wr || id_rd || nxt != ST_EMPTY)
                pend <= 1'b0;
            else if (thre_set || (fifo_en != fifo_en_q))
                pend <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        thre   = (state == ST_EMPTY);
        tx_irq = pend && fifo_en && tx_ie;
    end
endmodule

// File: rtl/txe_irq_chk.sv
module txe_irq_chk #(
    parameter int LEVEL_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [LEVEL_W-1:0] fifo_level,
    input logic               thr_wr,
    input logic               id_rd,
    input logic               fifo_en,
    input logic               tx_ie,
    input logic               thre,
    input logic               tx_irq
);
    assert_level_exits_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (thre && fifo_level != '0) |=> !thre);

    assert_fall_needs_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(thre) |-> $past(fifo_level) != '0);

    assert_rise_raises_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(thre) && !$past(thr_wr) && !$past(id_rd) && fifo_en && tx_ie) |-> tx_irq);

    assert_write_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !tx_irq);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        id_rd |=> !tx_irq);
endmodule

bind txe_irq_unit txe_irq_chk #(.LEVEL_W(LEVEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_level (fifo_level),
    .thr_wr     (thr_wr),
    .id_rd      (id_rd),
    .fifo_en    (fifo_en),
    .tx_ie      (tx_ie),
    .thre       (thre),
    .tx_irq     (tx_irq)
);

// File: tb/txe_irq_unit_test.sv
module txe_irq_unit_test;
    localparam int PERIOD = 10;
    localparam int NVEC   = 15;

    typedef struct packed {
        logic [4:0] lvl;
        logic wr, rd, stp, tk, fon, ie;
        logic ee, ei;
    } vec_t;

    // one row = inputs held for one cycle, expected outputs after that edge
    localparam vec_t TAB [NVEC] = '{
        '{5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R9 enable change while empty
        '{5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R8 id read clears
        '{5'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R2 leave empty
        '{5'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{5'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R3 two seen -> immediate
        '{5'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R10 memory cleared -> hold
        '{5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R4 sixth tick, 5 data bits
        '{5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}  // R8
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] fifo_level = '0;
    logic       thr_wr = 1'b0, id_rd = 1'b0, last_stop = 1'b0, baud_tick = 1'b0;
    logic [1:0] char_sel = 2'd0;
    logic       fifo_en = 1'b0, tx_ie = 1'b0;
    logic       thre, tx_irq;
    int         checks = 0;
    int         fails = 0;

    always #(PERIOD/2) clk = ~clk;

    txe_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .thr_wr(thr_wr),
        .id_rd(id_rd), .last_stop(last_stop), .baud_tick(baud_tick),
        .char_sel(char_sel), .fifo_en(fifo_en), .tx_ie(tx_ie),
        .thre(thre), .tx_irq(tx_irq)
    );

    task automatic chk(input string req, input logic exp_e, input logic exp_i);
        checks++;
        if (thre !== exp_e || tx_irq !== exp_i) begin
            fails++;
            $display("FAIL %s: thre=%b tx_irq=%b expected thre=%b tx_irq=%b",
                     req, thre, tx_irq, exp_e, exp_i);
        end
    endtask

    task automatic drive(input logic [4:0] l, input logic w, input logic r,
                         input logic s, input logic t);
        fifo_level = l; thr_wr = w; id_rd = r; last_stop = s; baud_tick = t;
        @(posedge clk);
        @(negedge clk);
        thr_wr = 1'b0; id_rd = 1'b0; last_stop = 1'b0; baud_tick = 1'b0;
    endtask

    initial begin
        #(PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", 1'b1, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 1'b1, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            fifo_en = TAB[i].fon;
            tx_ie   = TAB[i].ie;
            drive(TAB[i].lvl, TAB[i].wr, TAB[i].rd, TAB[i].stp, TAB[i].tk);
            chk($sformatf("table row %0d (R2 R3 R4 R8 R9 R10)", i), TAB[i].ee, TAB[i].ei);
        end

        // R5: last stop bit ends the hold early
        drive(5'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        drive(5'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(5'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R5 in hold", 1'b0, 1'b0);
        drive(5'd0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R5 last stop", 1'b1, 1'b1);
        drive(5'd0, 1'b0, 1'b1, 1'b0, 1'b0);

        // R6: write during hold cancels and restarts a full hold
        drive(5'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        drive(5'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(5'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        drive(5'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        drive(5'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R6 write cancels", 1'b0, 1'b0);
        drive(5'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 5; k++) drive(5'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R6 old count ignored", 1'b0, 1'b0);
        drive(5'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R6 fresh hold ends", 1'b1, 1'b1);
        drive(5'd0, 1'b0, 1'b1, 1'b0, 1'b0);

        // R4: eight data bits -> nine ticks
        char_sel = 2'd3;
        drive(5'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        drive(5'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 8; k++) drive(5'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R4 eight ticks of nine", 1'b0, 1'b0);
        drive(5'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R4 ninth tick", 1'b1, 1'b1);

        // R8: clear wins over a simultaneous set
        drive(5'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        drive(5'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(5'd0, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R8 read beats set", 1'b1, 1'b0);

        // R7: interrupt enable gates the request
        tx_ie = 1'b0;
        drive(5'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        drive(5'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(5'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 masked by tx_ie", 1'b1, 1'b0);
        tx_ie = 1'b1;
        #1;
        chk("R7 unmasked pending", 1'b1, 1'b1);

        // R3 / R7: FIFO disabled -> immediate empty, request gated
        fifo_en = 1'b0;
        drive(5'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 gated by fifo_en", 1'b1, 1'b0);
        drive(5'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        drive(5'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R3 fifo off immediate", 1'b1, 1'b0);
        drive(5'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        fifo_en = 1'b1;
        #1;
        chk("R9 not yet registered", 1'b1, 1'b0);
        drive(5'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 enable toggle raises", 1'b1, 1'b1);

        // R1: reset in mid activity
        drive(5'd3, 1'b1, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset", 1'b1, 1'b0);
        fifo_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule